// File: doc/BRIEF.md
# CEC Transmit Retry and Status Controller

This block runs one CEC transmit request from start to finish and reports how it ended. A host fills a frame buffer with up to `FRAME_BYTES` bytes through a simple register port. It sets the frame length, which counts the header byte plus the data bytes, and a retry limit. It then starts the request by setting the transmit-enable bit. The block hands the frame to a bus-level transmitter through an attempt interface. That transmitter reports one result per attempt: acknowledged, not acknowledged, arbitration lost, or a low-drive error.

Failed attempts are retried by the block itself until the limit is used up. An arbitration loss ends the request at once. Not-acknowledged and low-drive results are counted into two 4-bit saturating counters, which are packed into one readable byte. Each request ends with exactly one of three sticky completion flags: success, arbitration lost, or retry timeout. These flags drive a level interrupt and are cleared by writing ones to them. A clock-divider register carries the divisor for the bit-timing clock and a power field, and a request is accepted only while that field says the section is on.

Top module: `cec_tx_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is low, `att_start` is low and `cec_pwr` is low.
- R2: Writing 1 to bit 0 of the enable register (address FRAME_BYTES+2) starts a request only if the power field (bits [1:0] of the clock register, address FRAME_BYTES+5) is 01 and the length register (address FRAME_BYTES) holds a value from 1 to FRAME_BYTES. Otherwise the enable bit stays 0 and no attempt is issued.
- R3: Each attempt is announced by a one-cycle `att_start` pulse while `att_len` and `att_frame` present the programmed length and bytes, with buffer byte i (address i) at `att_frame[8*i+7:8*i]`.
- R4: Attempt result 00 (acknowledged) ends the request. It sets the success flag, bit 5 of the status register (address FRAME_BYTES+3), and clears the enable bit.
- R5: Attempt result 10 (arbitration lost) ends the request at once, with no retry even if retries remain, and sets status bit 4.
- R6: Results 01 (not acknowledged) and 11 (low drive) cause another attempt. Once 1 + N attempts have failed, where N is the retry field at bits starting at bit 4 of the retry register (address FRAME_BYTES+1), the request ends with status bit 3 (retry timeout).
- R7: The count register (address FRAME_BYTES+4) holds the not-acknowledged count in bits [3:0] and the low-drive count in bits [7:4]. Each count saturates at 15 and both are cleared when a request starts.
- R8: Each request sets exactly one of status bits [5:3].
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: While a request is in progress, writes to the frame, length, retry, enable and clock registers are ignored.
- R11: `irq` is high exactly when any status bit is set.
- R12: The clock register drives `cec_div` from its bits [7:2] and drives `cec_pwr` high when its bits [1:0] are 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Completion interrupt level |
| cec_div | output | 6 | Bit-timing clock divisor |
| cec_pwr | output | 1 | Section powered |
| att_start | output | 1 | One-cycle request for a bus attempt |
| att_len | output | clog2(FRAME_BYTES+1) | Frame length in bytes |
| att_frame | output | 8*FRAME_BYTES | Frame bytes, byte 0 lowest |
| att_done | input | 1 | Attempt finished, result valid |
| att_result | input | 2 | 00 ack, 01 nack, 10 arbitration lost, 11 low drive |

## Verification
The bench builds the block with FRAME_BYTES = 16 and RETRY_W = 4, which is one bit wider than the default retry field. A request can then run 16 attempts, and a run of 16 identical failures drives either counter into saturation; the 3-bit default cannot reach that. The full 16-byte length exercises the top boundary of the length check and the highest byte lane of the frame output. A zero length and a powered-down start cover the lower edge of the start conditions.

// File: rtl/cec_tx_pkg.sv
`timescale 1ns/1ps
package cec_tx_pkg;
   typedef enum logic [1:0] {
      RES_ACK    = 2'b00,
      RES_NACK   = 2'b01,
      RES_ARB    = 2'b10,
      RES_LOWDRV = 2'b11
   } att_res_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT
   } seq_st_e;

   localparam int CNT_W = 4;
   localparam int STAT_LSB = 3;
   localparam int RETRY_LSB = 4;
   localparam logic [1:0] PWR_ON = 2'b01;
endpackage

// File: rtl/cec_sat_ctr.sv
`timescale 1ns/1ps
module cec_sat_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (clr)              q <= '0;
      else if (inc && q != TOP)  q <= q + 1'b1;
   end

   // R7: a full counter stays full
   p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc && q == TOP) |=> q == TOP);
   // R7: a new request starts from zero
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> q == '0);
endmodule

// File: rtl/cec_tx_seq.sv
`timescale 1ns/1ps
module cec_tx_seq
   import cec_tx_pkg::*;
#(
   parameter int RETRY_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [RETRY_W-1:0] retry_lim,
   input  logic               att_done,
   input  logic [1:0]         att_result,
   output logic               att_start,
   output logic               busy,
   output logic               fin_ok,
   output logic               fin_arb,
   output logic               fin_tmo,
   output logic [CNT_W-1:0]   nack_cnt,
   output logic [CNT_W-1:0]   ldrv_cnt
);
   seq_st_e            st;
   logic [RETRY_W-1:0] tries;
   att_res_e           res;
   logic               seen, fail, last;

   assign res       = att_res_e'(att_result);
   assign att_start = (st == ST_ISSUE);
   assign busy      = (st != ST_IDLE);
   assign seen      = (st == ST_WAIT) && att_done;
   assign fail      = seen && (res == RES_NACK || res == RES_LOWDRV);
   assign last      = (tries == retry_lim);
   assign fin_ok    = seen && (res == RES_ACK);
   assign fin_arb   = seen && (res == RES_ARB);
   assign fin_tmo   = fail && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         tries <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (go) begin
               st    <= ST_ISSUE;
               tries <= '0;
            end
            ST_ISSUE: st <= ST_WAIT;
            ST_WAIT: if (att_done) begin
               if (fin_ok || fin_arb || fin_tmo) st <= ST_IDLE;
               else begin
                  st    <= ST_ISSUE;
                  tries <= tries + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   cec_sat_ctr #(.W(CNT_W)) u_nack (
      .clk(clk), .rst_n(rst_n), .clr(go),
      .inc(seen && res == RES_NACK), .q(nack_cnt));

   cec_sat_ctr #(.W(CNT_W)) u_ldrv (
      .clk(clk), .rst_n(rst_n), .clr(go),
      .inc(seen && res == RES_LOWDRV), .q(ldrv_cnt));

   p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      att_start |=> !att_start);
   p_one_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fin_ok, fin_arb, fin_tmo}));
   p_arb_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fin_arb |=> !busy);
   p_retry_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !last) |=> att_start);
   p_tries_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> tries <= retry_lim);
endmodule

// File: rtl/cec_tx_regs.sv
`timescale 1ns/1ps
module cec_tx_regs
   import cec_tx_pkg::*;
#(
   parameter int FRAME_BYTES = 16,
   parameter int RETRY_W     = 3,
   parameter int ADDR_W      = 5,
   parameter int LEN_W       = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [7:0]               bus_wdata,
   output logic [7:0]               bus_rdata,
   input  logic                     busy,
   input  logic                     fin_ok,
   input  logic                     fin_arb,
   input  logic                     fin_tmo,
   input  logic [CNT_W-1:0]         nack_cnt,
   input  logic [CNT_W-1:0]         ldrv_cnt,
   output logic                     go,
   output logic [RETRY_W-1:0]       retry_lim,
   output logic [FRAME_BYTES*8-1:0] frame,
   output logic [LEN_W-1:0]         len,
   output logic                     irq,
   output logic [5:0]               cec_div,
   output logic                     cec_pwr
);
   localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(FRAME_BYTES);
   localparam logic [ADDR_W-1:0] A_RETRY = ADDR_W'(FRAME_BYTES + 1);
   localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(FRAME_BYTES + 2);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(FRAME_BYTES + 3);
   localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(FRAME_BYTES + 4);
   localparam logic [ADDR_W-1:0] A_CLK   = ADDR_W'(FRAME_BYTES + 5);
   localparam logic [LEN_W-1:0]  LEN_MAX = LEN_W'(FRAME_BYTES);

   logic             wr_ok, en_q, fin_any;
   logic [2:0]       stat_q;
   logic [7:0]       clk_q;
   logic [7:0]       rd_tmp;

   assign wr_ok   = bus_wr && !busy;
   assign fin_any = fin_ok || fin_arb || fin_tmo;
   assign cec_div = clk_q[7:2];
   assign cec_pwr = (clk_q[1:0] == PWR_ON);
   assign irq     = |stat_q;
   assign go      = wr_ok && bus_addr == A_EN && bus_wdata[0] && cec_pwr
                    && len != '0 && len <= LEN_MAX;

   for (genvar i = 0; i < FRAME_BYTES; i++) begin : g_byte
      logic [7:0] b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) b_q <= '0;
         else if (wr_ok && bus_addr == ADDR_W'(i)) b_q <= bus_wdata;
      end
      assign frame[i*8 +: 8] = b_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len       <= '0;
         retry_lim <= '0;
         clk_q     <= '0;
         en_q      <= 1'b0;
         stat_q    <= '0;
      end else begin
         if (wr_ok && bus_addr == A_LEN)   len       <= bus_wdata[LEN_W-1:0];
         if (wr_ok && bus_addr == A_RETRY) retry_lim <= bus_wdata[RETRY_LSB +: RETRY_W];
         if (wr_ok && bus_addr == A_CLK)   clk_q     <= bus_wdata;
         if (go)           en_q <= 1'b1;
         else if (fin_any) en_q <= 1'b0;
         stat_q <= (stat_q & ~((bus_wr && bus_addr == A_STAT) ?
                               bus_wdata[STAT_LSB +: 3] : 3'b000))
                   | {fin_ok, fin_arb, fin_tmo};
      end
   end

   always_comb begin
      rd_tmp = '0;
      unique case (bus_addr)
         A_LEN:   rd_tmp = 8'(len);
         A_RETRY: rd_tmp[RETRY_LSB +: RETRY_W] = retry_lim;
         A_EN:    rd_tmp[0] = en_q;
         A_STAT:  rd_tmp[STAT_LSB +: 3] = stat_q;
         A_CNT:   rd_tmp = {ldrv_cnt, nack_cnt};
         A_CLK:   rd_tmp = clk_q;
         default: begin
            for (int i = 0; i < FRAME_BYTES; i++)
               if (bus_addr == ADDR_W'(i)) rd_tmp = frame[i*8 +: 8];
         end
      endcase
   end
   assign bus_rdata = rd_tmp;

   p_end_drops_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fin_any |=> !en_q);
   p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_wr && bus_addr == A_LEN) |=> len == $past(len));
   p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_STAT && bus_wdata[STAT_LSB] && !fin_tmo)
      |=> !stat_q[0]);
   p_flag_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fin_ok |=> stat_q[2]);
endmodule

// File: rtl/cec_tx_ctrl.sv
`timescale 1ns/1ps
module cec_tx_ctrl
   import cec_tx_pkg::*;
#(
   parameter int FRAME_BYTES = 16,
   parameter int RETRY_W     = 3,
   parameter int ADDR_W      = 5
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               bus_wr,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic [7:0]                         bus_wdata,
   output logic [7:0]                         bus_rdata,
   output logic                               irq,
   output logic [5:0]                         cec_div,
   output logic                               cec_pwr,
   output logic                               att_start,
   output logic [$clog2(FRAME_BYTES+1)-1:0]   att_len,
   output logic [FRAME_BYTES*8-1:0]           att_frame,
   input  logic                               att_done,
   input  logic [1:0]                         att_result
);
   localparam int LEN_W = $clog2(FRAME_BYTES + 1);

   if (RETRY_W < 1 || RETRY_W > 4) begin : g_bad_retry
      $error("RETRY_W must be 1 to 4");
   end
   if ((1 << ADDR_W) < FRAME_BYTES + 6) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (FRAME_BYTES < 2 || LEN_W > 8) begin : g_bad_frame
      $error("FRAME_BYTES out of range");
   end

   logic               go, busy, fin_ok, fin_arb, fin_tmo;
   logic [RETRY_W-1:0] retry_lim;
   logic [CNT_W-1:0]   nack_cnt, ldrv_cnt;

   cec_tx_regs #(
      .FRAME_BYTES(FRAME_BYTES), .RETRY_W(RETRY_W),
      .ADDR_W(ADDR_W), .LEN_W(LEN_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .busy(busy),
      .fin_ok(fin_ok), .fin_arb(fin_arb), .fin_tmo(fin_tmo),
      .nack_cnt(nack_cnt), .ldrv_cnt(ldrv_cnt),
      .go(go), .retry_lim(retry_lim), .frame(att_frame), .len(att_len),
      .irq(irq), .cec_div(cec_div), .cec_pwr(cec_pwr)
   );

   cec_tx_seq #(.RETRY_W(RETRY_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .retry_lim(retry_lim),
      .att_done(att_done), .att_result(att_result),
      .att_start(att_start), .busy(busy),
      .fin_ok(fin_ok), .fin_arb(fin_arb), .fin_tmo(fin_tmo),
      .nack_cnt(nack_cnt), .ldrv_cnt(ldrv_cnt)
   );

   p_irq_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_ok || fin_arb || fin_tmo) |=> irq);
endmodule

// File: tb/sim_cec_tx_ctrl.sv
`timescale 1ns/1ps
module sim_cec_tx_ctrl;
   localparam int FB = 16;
   localparam int RW = 4;
   localparam int AW = 5;
   localparam logic [AW-1:0] A_LEN = 16, A_RETRY = 17, A_EN = 18,
                             A_STAT = 19, A_CNT = 20, A_CLK = 21;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0]    bus_wdata = '0, bus_rdata;
   logic          irq, cec_pwr, att_start;
   logic [5:0]    cec_div;
   logic [4:0]    att_len;
   logic [FB*8-1:0] att_frame;
   logic          att_done = 1'b0;
   logic [1:0]    att_result = 2'b00;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;   // 125 MHz

   cec_tx_ctrl #(.FRAME_BYTES(FB), .RETRY_W(RW), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .cec_div(cec_div), .cec_pwr(cec_pwr), .att_start(att_start),
      .att_len(att_len), .att_frame(att_frame),
      .att_done(att_done), .att_result(att_result));

   // {retry limit, per-attempt results from bit 0 upward}
   localparam logic [35:0] VEC [8] = '{
      {4'd3,  32'h0000_0000},
      {4'd3,  32'h0000_0005},
      {4'd2,  32'h0000_001D},
      {4'd5,  32'h0000_000B},
      {4'd0,  32'h0000_0001},
      {4'd15, 32'h5555_5555},
      {4'd15, 32'hFFFF_FFFF},
      {4'd7,  32'h0000_0002}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // expected outcome derived from the requirements
   task automatic model(input logic [3:0] rl, input logic [31:0] pat,
                        output int att, output logic [7:0] st, output logic [7:0] cnt);
      int n = 0, l = 0;
      att = 0; st = 0;
      for (int k = 0; k < 16; k++) begin
         logic [1:0] r = pat[2*k +: 2];
         att++;
         if (r == 2'b00) begin st = 8'h20; break; end
         if (r == 2'b10) begin st = 8'h10; break; end
         if (r == 2'b01 && n < 15) n++;
         if (r == 2'b11 && l < 15) l++;
         if (k == int'(rl)) begin st = 8'h08; break; end
      end
      cnt = {4'(l), 4'(n)};
   endtask

   task automatic drive_attempts(input logic [31:0] pat, output int att, output bit frm_ok);
      att = 0; frm_ok = 1;
      while (att < 40 && att_start === 1'b1) begin
         if (att_len !== 5'd16 || att_frame[7:0] !== 8'hA0 || att_frame[127:120] !== 8'hAF)
            frm_ok = 0;
         @(negedge clk);
         att_done = 1'b1; att_result = pat[2*(att%16) +: 2];
         att++;
         @(negedge clk);
         att_done = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, exp_st, exp_cnt;
      int att, exp_att;
      bit fok;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(A_LEN, d);  chk("R1 len", d, 0);
      rd(A_EN, d);   chk("R1 enable", d, 0);
      rd(A_STAT, d); chk("R1 status", d, 0);
      rd(A_CNT, d);  chk("R1 counts", d, 0);
      rd(A_CLK, d);  chk("R1 clock reg", d, 0);
      chk("R1 irq/start/pwr", {irq, att_start, cec_pwr}, 0);

      for (int i = 0; i < FB; i++) wr(AW'(i), 8'hA0 + 8'(i));
      wr(A_LEN, 8'd16);
      // R2 powered down: start ignored
      wr(A_EN, 8'h01);
      chk("R2 no attempt when off", att_start, 0);
      rd(A_EN, d); chk("R2 enable stays 0 when off", d, 0);

      // R12 divider and power
      wr(A_CLK, 8'h5D);
      chk("R12 divisor", cec_div, 6'd23);
      chk("R12 power", cec_pwr, 1);

      // R2 zero length
      wr(A_LEN, 8'd0);
      wr(A_EN, 8'h01);
      chk("R2 no attempt at length 0", att_start, 0);
      wr(A_LEN, 8'd16);

      for (int v = 0; v < 8; v++) begin
         logic [3:0]  rl  = VEC[v][35:32];
         logic [31:0] pat = VEC[v][31:0];
         model(rl, pat, exp_att, exp_st, exp_cnt);
         wr(A_STAT, 8'h38);
         wr(A_RETRY, {rl, 4'b0});
         wr(A_EN, 8'h01);
         drive_attempts(pat, att, fok);
         chk($sformatf("R3 frame/len vec%0d", v), fok, 1);
         chk($sformatf("R6 attempts vec%0d", v), att, exp_att);
         rd(A_STAT, d);
         chk($sformatf("R4 R5 R6 R8 status vec%0d", v), d, exp_st);
         rd(A_CNT, d);
         chk($sformatf("R7 counts vec%0d", v), d, exp_cnt);
         rd(A_EN, d);
         chk($sformatf("R4 enable cleared vec%0d", v), d, 0);
         chk($sformatf("R11 irq vec%0d", v), irq, 1);
      end

      // R10 writes ignored while busy
      wr(A_STAT, 8'h38);
      wr(A_RETRY, 8'h00);
      wr(A_LEN, 8'd3);
      wr(A_EN, 8'h01);
      chk("R3 start pulse", att_start, 1);
      wr(A_LEN, 8'd9);
      wr(8'd0, 8'h55);
      rd(A_LEN, d); chk("R10 length kept while busy", d, 3);
      chk("R10 frame byte kept while busy", att_frame[7:0], 8'hA0);
      att_done = 1'b1; att_result = 2'b00;
      @(negedge clk);
      att_done = 1'b0;
      rd(A_STAT, d); chk("R4 success flag", d, 8'h20);

      // R9 write-one-to-clear
      wr(A_STAT, 8'h00);
      rd(A_STAT, d); chk("R9 zero write keeps flag", d, 8'h20);
      chk("R11 irq held", irq, 1);
      wr(A_STAT, 8'h20);
      rd(A_STAT, d); chk("R9 one write clears flag", d, 8'h00);
      chk("R11 irq dropped", irq, 0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule